// File: doc/BRIEF.md
# Interrupt Pending Resolver with Delegation

This block decides, in a single combinational pass, whether an interrupt should be taken right now. When one is taken, it also gives the interrupt's cause code and the privilege level (Machine or Supervisor) that handles it. Its inputs are the machine pending, enable and interrupt-delegation words, the hart's current privilege, the global interrupt-enable bits for machine and supervisor level, and a flag that says whether supervisor mode is implemented. It sits between the interrupt CSRs and the trap-entry logic of a core, which samples the result at instruction boundaries.

The resolution runs in two stages. Undelegated sources that are both pending and enabled form the machine-level set. Pending sources that are delegated form the supervisor set. Each set is gated by an enable that depends on the current privilege. A fixed priority search then runs over whichever set wins. Only six source bits take part. Every other bit of the input words is ignored.

Top module: `irq_resolver`

## Requirements
- R1: If no source is both pending and enabled (after restricting to the six source bits), `irqValid` is 0.
- R2: A source whose delegation bit is 1 never reaches Machine. A delegated source can be taken by Supervisor, and this includes the machine-level source bits 11, 7 and 3.
- R3: Machine-level interrupts are taken when `curPriv` is not Machine (2'b11), or when it is Machine and `mStatusIe` is 1.
- R4: Supervisor interrupts are taken only when `sModePresent` is 1 and either `curPriv` is User (2'b00) or `curPriv` is Supervisor (2'b01) with `sStatusIe` 1.
- R5: When the machine-level set is non-empty and machine interrupts are taken, the target is Machine, even if the delegated set is also non-empty and Supervisor is enabled.
- R6: Within the chosen set, priority from highest to lowest is bit 11, bit 3, bit 7, bit 9, bit 1, bit 5.
- R7: `irqCause` is the bit index of the selected source. `irqTarget` is 2'b11 for Machine and 2'b01 for Supervisor. When `irqValid` is 0, both outputs are zero.
- R8: Pending, enable and delegation bits outside positions 11, 9, 7, 5, 3, 1 have no effect on any output.
- R9: Apart from the check in R1, the delegated set does not consult the enable word. A delegated source that is pending but not enabled can be selected once some other source passes the check in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pendIn | input | XLEN | Machine interrupt pending word |
| enableIn | input | XLEN | Machine interrupt enable word |
| delegIn | input | XLEN | Machine interrupt delegation word |
| curPriv | input | 2 | Current privilege: 00 User, 01 Supervisor, 11 Machine |
| mStatusIe | input | 1 | Machine global interrupt enable |
| sStatusIe | input | 1 | Supervisor global interrupt enable |
| sModePresent | input | 1 | Supervisor mode implemented |
| irqValid | output | 1 | An interrupt is to be taken |
| irqCause | output | CAUSE_W | Bit index of the selected source |
| irqTarget | output | 2 | Handling privilege: 11 Machine, 01 Supervisor |

## Verification
The two functions that can coincide are the machine-level selection and the supervisor selection. This happens when the machine-level set and the delegated set are both non-empty in the same evaluation. The bench provokes it with directed vectors that mix delegated and undelegated pending sources under each privilege. It also uses random words with biased delegation masks. A reference function that applies the enable and precedence rules from the requirements judges each vector, and the bench compares that function's expected cause and target with the outputs.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned SRC_MEI = 11;
  localparam int unsigned SRC_SEI = 9;
  localparam int unsigned SRC_MTI = 7;
  localparam int unsigned SRC_STI = 5;
  localparam int unsigned SRC_MSI = 3;
  localparam int unsigned SRC_SSI = 1;
  localparam int unsigned NUM_SRC = 6;

  // highest priority first
  localparam int unsigned PRIO_ORDER [NUM_SRC] = '{SRC_MEI, SRC_MSI, SRC_MTI,
                                                   SRC_SEI, SRC_SSI, SRC_STI};

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_MACH  = 2'b11
  } priv_e;

  typedef struct packed {
    logic takeMachine;
    logic takeSuper;
  } selStrobe_t;
endpackage

// File: rtl/irq_sets.sv
module irq_sets #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pendIn,
  input  logic [XLEN-1:0] enableIn,
  input  logic [XLEN-1:0] delegIn,
  output logic [XLEN-1:0] machSet,
  output logic [XLEN-1:0] delegSet,
  output logic            anyEnabled
);
  import irq_res_pkg::*;

  logic [XLEN-1:0] srcMask;
  logic [XLEN-1:0] pendEn;

  always_comb begin
    srcMask = '0;
    for (int i = 0; i < int'(NUM_SRC); i++) srcMask[PRIO_ORDER[i]] = 1'b1;
  end

  assign pendEn     = pendIn & enableIn & srcMask;
  assign anyEnabled = |pendEn;
  assign machSet    = pendEn & ~delegIn;
  assign delegSet   = pendIn & delegIn & srcMask;
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl (
  input  logic [1:0]                  curPriv,
  input  logic                        mStatusIe,
  input  logic                        sStatusIe,
  input  logic                        sModePresent,
  input  logic                        anyEnabled,
  input  logic                        machNonzero,
  input  logic                        delegNonzero,
  output irq_res_pkg::selStrobe_t     strobe
);
  import irq_res_pkg::*;

  logic mEnable;
  logic sEnable;

  assign mEnable = (curPriv != PRIV_MACH) || mStatusIe;
  assign sEnable = sModePresent &&
                   ((curPriv == PRIV_USER) || ((curPriv == PRIV_SUPER) && sStatusIe));

  always_comb begin
    strobe = '0;
    if (anyEnabled) begin
      if (mEnable && machNonzero)       strobe.takeMachine = 1'b1;
      else if (sEnable && delegNonzero) strobe.takeSuper   = 1'b1;
    end
  end

  always_comb begin
    AST_ONE_STROBE: assert (!(strobe.takeMachine && strobe.takeSuper)); // R5
    AST_FAST_PATH: assert (anyEnabled || strobe == '0); // R1
    AST_SUPER_NEEDS_MODE: assert (!strobe.takeSuper || sModePresent); // R4
    AST_MACH_BLOCKED: assert (!(curPriv == PRIV_MACH && !mStatusIe) || !strobe.takeMachine); // R3
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]          machSet,
  input  logic [XLEN-1:0]          delegSet,
  input  irq_res_pkg::selStrobe_t  strobe,
  output logic                     irqValid,
  output logic [CAUSE_W-1:0]       irqCause,
  output logic [1:0]               irqTarget
);
  import irq_res_pkg::*;

  logic [XLEN-1:0]    chosenSet;
  logic               hit;
  logic [CAUSE_W-1:0] hitIdx;

  assign chosenSet = strobe.takeMachine ? machSet :
                     strobe.takeSuper   ? delegSet : '0;

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = int'(NUM_SRC) - 1; i >= 0; i--) begin
      if (chosenSet[PRIO_ORDER[i]]) begin
        hit    = 1'b1;
        hitIdx = CAUSE_W'(PRIO_ORDER[i]);
      end
    end
  end

  assign irqValid  = hit;
  assign irqCause  = hit ? hitIdx : '0;
  assign irqTarget = !hit ? 2'b00 :
                     strobe.takeMachine ? PRIV_MACH : PRIV_SUPER;

  always_comb begin
    AST_IDLE_ZERO: assert (irqValid || (irqCause == '0 && irqTarget == 2'b00)); // R7
    AST_TARGET_LEGAL: assert (!irqValid || irqTarget == PRIV_MACH || irqTarget == PRIV_SUPER); // R7
    AST_CAUSE_IN_SET: assert (!irqValid || chosenSet[irqCause]); // R6
    AST_MACH_UNDELEG: assert (!(irqValid && irqTarget == PRIV_MACH) || machSet[irqCause]); // R2
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]    pendIn,
  input  logic [XLEN-1:0]    enableIn,
  input  logic [XLEN-1:0]    delegIn,
  input  logic [1:0]         curPriv,
  input  logic               mStatusIe,
  input  logic               sStatusIe,
  input  logic               sModePresent,
  output logic               irqValid,
  output logic [CAUSE_W-1:0] irqCause,
  output logic [1:0]         irqTarget
);
  import irq_res_pkg::*;

  logic [XLEN-1:0] machSet;
  logic [XLEN-1:0] delegSet;
  logic            anyEnabled;
  selStrobe_t      strobe;

  irq_sets #(.XLEN(XLEN)) uSets (
    .pendIn(pendIn), .enableIn(enableIn), .delegIn(delegIn),
    .machSet(machSet), .delegSet(delegSet), .anyEnabled(anyEnabled)
  );

  irq_gate_ctrl uCtrl (
    .curPriv(curPriv), .mStatusIe(mStatusIe), .sStatusIe(sStatusIe),
    .sModePresent(sModePresent), .anyEnabled(anyEnabled),
    .machNonzero(|machSet), .delegNonzero(|delegSet), .strobe(strobe)
  );

  irq_pick #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) uPick (
    .machSet(machSet), .delegSet(delegSet), .strobe(strobe),
    .irqValid(irqValid), .irqCause(irqCause), .irqTarget(irqTarget)
  );
endmodule

// File: tb/tb_irq_resolver.sv
module tb_irq_resolver;
  localparam int XLEN = 64;
  localparam int CW = 6;
  localparam int CLK_PERIOD = 10;
  localparam logic [XLEN-1:0] SIX = 64'h0AAA;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [XLEN-1:0] pend, en, dlg;
  logic [1:0] priv;
  logic mie, sie, sp;
  logic irqValid;
  logic [CW-1:0] irqCause;
  logic [1:0] irqTarget;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  irq_resolver #(.XLEN(XLEN)) dut (
    .pendIn(pend), .enableIn(en), .delegIn(dlg), .curPriv(priv),
    .mStatusIe(mie), .sStatusIe(sie), .sModePresent(sp),
    .irqValid(irqValid), .irqCause(irqCause), .irqTarget(irqTarget)
  );

  function automatic logic [8:0] model(logic [XLEN-1:0] p, logic [XLEN-1:0] e,
      logic [XLEN-1:0] d, logic [1:0] pv, logic mi, logic si, logic s);
    logic [XLEN-1:0] ms, ds, set;
    logic mOk, sOk;
    logic [1:0] tgt;
    int order [6] = '{11, 3, 7, 9, 1, 5};
    if (((p & e) & SIX) == '0) return 9'd0;
    ms  = p & e & ~d & SIX;
    ds  = p & d & SIX;
    mOk = (pv != 2'b11) || mi;
    sOk = s && (pv == 2'b00 || (pv == 2'b01 && si));
    if (mOk && ms != '0) begin set = ms; tgt = 2'b11; end
    else if (sOk && ds != '0) begin set = ds; tgt = 2'b01; end
    else return 9'd0;
    foreach (order[i]) if (set[order[i]]) return {1'b1, 6'(order[i]), tgt};
    return 9'd0;
  endfunction

  task automatic apply(logic [XLEN-1:0] p, logic [XLEN-1:0] e, logic [XLEN-1:0] d,
      logic [1:0] pv, logic mi, logic si, logic s);
    @(negedge clk);
    pend = p; en = e; dlg = d; priv = pv; mie = mi; sie = si; sp = s;
    #1;
  endtask

  task automatic check(string req, logic ev, logic [5:0] ec, logic [1:0] et);
    checks++;
    if (irqValid !== ev || irqCause !== ec || irqTarget !== et) begin
      fails++;
      $display("FAIL %s: got valid=%0b cause=%0d target=%0b, expected valid=%0b cause=%0d target=%0b",
               req, irqValid, irqCause, irqTarget, ev, ec, et);
    end
  endtask

  task automatic checkModel(string req);
    logic [8:0] x;
    x = model(pend, en, dlg, priv, mie, sie, sp);
    check(req, x[8], x[7:2], x[1:0]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    apply('0, '0, '0, 2'b11, 0, 0, 0);
    check("R1 idle", 0, 0, 0);
    apply(SIX, '0, '0, 2'b00, 1, 1, 1);
    check("R1 none enabled", 0, 0, 0);
    // R3
    apply(64'h80, 64'h80, '0, 2'b11, 0, 0, 1);
    check("R3 M blocked", 0, 0, 0);
    apply(64'h80, 64'h80, '0, 2'b11, 1, 0, 1);
    check("R3 M with MIE", 1, 7, 2'b11);
    apply(64'h80, 64'h80, '0, 2'b00, 0, 0, 1);
    check("R3 from U", 1, 7, 2'b11);
    // R4
    apply(64'h200, 64'h200, 64'h200, 2'b01, 0, 0, 1);
    check("R4 S without SIE", 0, 0, 0);
    apply(64'h200, 64'h200, 64'h200, 2'b01, 0, 1, 1);
    check("R4 S with SIE", 1, 9, 2'b01);
    apply(64'h200, 64'h200, 64'h200, 2'b00, 0, 0, 0);
    check("R4 no S mode", 0, 0, 0);
    // R5 and R2
    apply(64'h880, 64'h880, 64'h800, 2'b01, 0, 1, 1);
    check("R5 machine wins", 1, 7, 2'b11);
    apply(64'h800, 64'h800, 64'h800, 2'b00, 1, 1, 1);
    check("R2 delegated MEI", 1, 11, 2'b01);
    apply(64'h800, 64'h800, 64'h800, 2'b11, 1, 1, 1);
    check("R2 delegated MEI in M", 0, 0, 0);
    // R6
    apply(SIX, SIX, '0, 2'b00, 0, 0, 1);
    check("R6 top", 1, 11, 2'b11);
    apply(64'h0AA, SIX, '0, 2'b00, 0, 0, 1);
    check("R6 MSI", 1, 3, 2'b11);
    apply(64'h2A2, SIX, '0, 2'b00, 0, 0, 1);
    check("R6 MTI", 1, 7, 2'b11);
    apply(SIX, SIX, SIX, 2'b00, 0, 0, 1);
    check("R6 S top", 1, 11, 2'b01);
    apply(64'h222, SIX, SIX, 2'b00, 0, 0, 1);
    check("R6 SEI", 1, 9, 2'b01);
    apply(64'h022, SIX, SIX, 2'b00, 0, 0, 1);
    check("R6 SSI", 1, 1, 2'b01);
    apply(64'h020, SIX, SIX, 2'b00, 0, 0, 1);
    check("R6 STI", 1, 5, 2'b01);
    // R8
    apply(~SIX, ~SIX, '0, 2'b00, 1, 1, 1);
    check("R8 other bits", 0, 0, 0);
    apply(~SIX | 64'h8, ~SIX | 64'h8, ~SIX, 2'b00, 1, 1, 1);
    check("R8 MSI among noise", 1, 3, 2'b11);
    // R9
    apply(64'h202, 64'h002, 64'h202, 2'b00, 0, 0, 1);
    check("R9 unenabled delegated", 1, 9, 2'b01);
    // R7 random sweep
    for (int k = 0; k < 600; k++) begin
      logic [XLEN-1:0] rp, re, rd;
      rp = {$urandom, $urandom}; re = {$urandom, $urandom}; rd = {$urandom, $urandom};
      if (k % 3 == 0) rd = rd & {$urandom, $urandom};
      if (k % 4 == 1) re = re & rp & SIX & {$urandom, $urandom};
      apply(rp, re, rd, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      checkModel("R7 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule